// File: doc/BRIEF.md
# Instruction Operand Resolution Unit

This block takes one 32-bit instruction word together with a snapshot of the eight general registers. It works out where the instruction's second operand lives and what its value is. It splits the word into an opcode, a destination register index (Rj), a two-bit addressing mode, an index register selector (Ri) and a 16-bit address/constant part.

The address part is sign-extended and, when an index register is named, added to that register. The mode then decides what happens to the result. Immediate mode uses it directly. Direct mode makes one memory read. Indirect mode makes two chained reads. Instructions whose second operand is a destination (the store and branch groups) stop one read early and return the effective address.

Memory is reached through a one-cycle request pulse and a response valid that may arrive any number of cycles later. A one-cycle done pulse tells the surrounding pipeline that the effective address and operand outputs are ready. A new instruction is taken only while the unit is idle.

Top module: `operand_resolver`

## Requirements
- R1: Opcode bits 31..24 and Rj bits 23..21 of the instruction accepted are presented on opcode_o and rj_o from the cycle after acceptance, and stay unchanged until the next acceptance.
- R2: Ri bits 18..16 select the index register; a nonzero Ri adds that register's value to the base, and Ri = 0 means no index, whatever R0 holds.
- R3: The address part (bits 15..0) is sign-extended to 32 bits before the index add, and the sum wraps modulo 2^32.
- R4: Mode bits 20..19 = 0 (immediate) give ea_o = operand_o = base, with no memory request and done_o in the cycle right after acceptance.
- R5: Mode 1 (direct) issues one read at the base; ea_o = base and operand_o = the word returned.
- R6: Mode 2 (indirect) reads the word at the base, uses it as ea_o, then reads again at that address; operand_o = the second word returned.
- R7: For opcodes 0x01 and 0x20 through 0x2C the final data read is skipped: direct mode makes no read and gives ea_o = base, indirect mode makes one read and gives ea_o = the pointer read. In both cases operand_o = ea_o. Opcode 0x2D is resolved normally.
- R8: Mode 3 finishes with illegal_o = 1 together with done_o and makes no memory request. illegal_o is 0 after every legal-mode instruction.
- R9: done_o is high for exactly one cycle per accepted instruction, and busy_o is high from the cycle after acceptance up to and including the done cycle.
- R10: start_i is ignored while busy_o is high, including the done cycle. The instruction word present while busy has no effect.
- R11: After reset, busy_o, done_o, illegal_o and mem_req_o are 0, and ea_o, operand_o, opcode_o and rj_o are 0.
- R12: Each read is a single-cycle mem_req_o pulse with its address on mem_addr_o. The unit waits any number of cycles for mem_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to resolve instr_i (taken only when idle) |
| instr_i | input | 32 | Instruction word |
| regs_i | input | 256 | Register file, R0 in bits 31..0 up to R7 in bits 255..224 |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| illegal_o | output | 1 | Last instruction carried mode 3 |
| opcode_o | output | 8 | Opcode of the accepted instruction |
| rj_o | output | 3 | First-operand register index |
| ea_o | output | 32 | Effective address of the second operand |
| operand_o | output | 32 | Value of the second operand |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 32 | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The finishing done pulse of one instruction and a start request for the next can fall in the same cycle. The bench holds start_i high through a whole direct-mode resolution and swaps instr_i for a different immediate instruction midway. It then judges that the first result carries the first instruction's opcode and operand, that the unit is idle and not busy in the cycle after done, and that only then does the second instruction complete with its own values. Varying memory latency per vector also moves the response valid relative to the request pulse.

// File: rtl/oprs_pkg.sv
package oprs_pkg;
   localparam int OPC_W  = 8;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_IMM = 2'd0,
      MODE_DIR = 2'd1,
      MODE_IND = 2'd2,
      MODE_BAD = 2'd3
   } mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ1,
      ST_WAIT1,
      ST_REQ2,
      ST_WAIT2,
      ST_DONE
   } state_e;

   // opcodes whose second operand is a target location
   function automatic logic is_dest_op(input logic [OPC_W-1:0] op);
      return (op == 8'h01) || ((op >= 8'h20) && (op <= 8'h2C));
   endfunction
endpackage

// File: rtl/oprs_fields.sv
module oprs_fields
   import oprs_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int PART_W = 16,
   localparam int IDX_W   = $clog2(NREG),
   localparam int INSTR_W = OPC_W + IDX_W + MODE_W + IDX_W + PART_W
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [OPC_W-1:0]   opcode_o,
   output logic [IDX_W-1:0]   rj_o,
   output mode_e              mode_o,
   output logic [IDX_W-1:0]   ri_o,
   output logic [PART_W-1:0]  part_o
);
   localparam int RI_LO   = PART_W;
   localparam int MODE_LO = RI_LO + IDX_W;
   localparam int RJ_LO   = MODE_LO + MODE_W;
   localparam int OPC_LO  = RJ_LO + IDX_W;

   always_comb begin
      opcode_o = instr_i[OPC_LO +: OPC_W];
      rj_o     = instr_i[RJ_LO +: IDX_W];
      mode_o   = mode_e'(instr_i[MODE_LO +: MODE_W]);
      ri_o     = instr_i[RI_LO +: IDX_W];
      part_o   = instr_i[PART_W-1:0];
   end
endmodule

// File: rtl/oprs_base.sv
module oprs_base #(
   parameter int  DATA_W   = 32,
   parameter int  NREG     = 8,
   parameter int  PART_W   = 16,
   parameter bit  SIGN_EXT = 1'b1,
   localparam int IDX_W    = $clog2(NREG)
) (
   input  logic [PART_W-1:0]      part_i,
   input  logic [IDX_W-1:0]       ri_i,
   input  logic [NREG*DATA_W-1:0] regs_i,
   output logic [DATA_W-1:0]      base_o
);
   localparam int EXT_W = DATA_W - PART_W;

   logic [DATA_W-1:0] part_ext;
   logic [DATA_W-1:0] idx_val;

   if (SIGN_EXT) begin : g_sext
      assign part_ext = {{EXT_W{part_i[PART_W-1]}}, part_i};
   end else begin : g_zext
      assign part_ext = {{EXT_W{1'b0}}, part_i};
   end

   // selector value zero means "no index register"
   always_comb begin
      idx_val = '0;
      if (ri_i != '0) idx_val = regs_i[int'(ri_i)*DATA_W +: DATA_W];
   end

   assign base_o = part_ext + idx_val;
endmodule

// File: rtl/oprs_seq.sv
module oprs_seq
   import oprs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  mode_e             mode_i,
   input  logic              dest_i,
   input  logic [DATA_W-1:0] base_i,
   input  logic              mem_valid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              accept_o,
   output logic              mem_req_o,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] ea_o,
   output logic [DATA_W-1:0] operand_o,
   output logic              done_o,
   output logic              busy_o,
   output logic              illegal_o
);
   state_e            state_q;
   mode_e             mode_q;
   logic              dest_q;
   logic              ill_q;
   logic [DATA_W-1:0] ea_q;
   logic [DATA_W-1:0] opnd_q;

   assign accept_o = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_IMM;
         dest_q  <= 1'b0;
         ill_q   <= 1'b0;
         ea_q    <= '0;
         opnd_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               mode_q <= mode_i;
               dest_q <= dest_i;
               ea_q   <= base_i;
               ill_q  <= (mode_i == MODE_BAD);
               if (mode_i == MODE_BAD) begin
                  opnd_q  <= '0;
                  state_q <= ST_DONE;
               end else if ((mode_i == MODE_IMM) ||
                            ((mode_i == MODE_DIR) && dest_i)) begin
                  opnd_q  <= base_i;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_REQ1;
               end
            end
            ST_REQ1: state_q <= ST_WAIT1;
            ST_WAIT1: if (mem_valid_i) begin
               if (mode_q == MODE_IND) begin
                  ea_q <= mem_rdata_i;
                  if (dest_q) begin
                     opnd_q  <= mem_rdata_i;
                     state_q <= ST_DONE;
                  end else begin
                     state_q <= ST_REQ2;
                  end
               end else begin
                  opnd_q  <= mem_rdata_i;
                  state_q <= ST_DONE;
               end
            end
            ST_REQ2: state_q <= ST_WAIT2;
            ST_WAIT2: if (mem_valid_i) begin
               opnd_q  <= mem_rdata_i;
               state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ea_q holds the base for the first read and the pointer for the second
   assign mem_req_o  = (state_q == ST_REQ1) || (state_q == ST_REQ2);
   assign mem_addr_o = ea_q;
   assign ea_o       = ea_q;
   assign operand_o  = opnd_q;
   assign done_o     = (state_q == ST_DONE);
   assign busy_o     = (state_q != ST_IDLE);
   assign illegal_o  = ill_q;

   AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |=> !mem_req_o); // R12
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R9
   AST_IMM_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && mode_i == MODE_IMM) |=> (done_o && !mem_req_o)); // R4
   AST_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && mode_i == MODE_BAD) |=> (done_o && illegal_o && !mem_req_o)); // R8
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
   import oprs_pkg::*;
#(
   parameter int  DATA_W   = 32,
   parameter int  NREG     = 8,
   parameter int  PART_W   = 16,
   parameter bit  SIGN_EXT = 1'b1,
   localparam int IDX_W    = $clog2(NREG),
   localparam int INSTR_W  = OPC_W + IDX_W + MODE_W + IDX_W + PART_W
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   start_i,
   input  logic [INSTR_W-1:0]     instr_i,
   input  logic [NREG*DATA_W-1:0] regs_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   illegal_o,
   output logic [OPC_W-1:0]       opcode_o,
   output logic [IDX_W-1:0]       rj_o,
   output logic [DATA_W-1:0]      ea_o,
   output logic [DATA_W-1:0]      operand_o,
   output logic                   mem_req_o,
   output logic [DATA_W-1:0]      mem_addr_o,
   input  logic                   mem_valid_i,
   input  logic [DATA_W-1:0]      mem_rdata_i
);
   if (DATA_W <= PART_W) begin : g_bad_width
      $error("DATA_W must exceed PART_W");
   end
   if (NREG < 2 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two, at least 2");
   end

   logic [OPC_W-1:0]  f_opc;
   logic [IDX_W-1:0]  f_rj;
   logic [IDX_W-1:0]  f_ri;
   mode_e             f_mode;
   logic [PART_W-1:0] f_part;
   logic [DATA_W-1:0] base;
   logic              accept;

   oprs_fields #(.NREG(NREG), .PART_W(PART_W)) fields_i (
      .instr_i (instr_i),
      .opcode_o(f_opc),
      .rj_o    (f_rj),
      .mode_o  (f_mode),
      .ri_o    (f_ri),
      .part_o  (f_part)
   );

   oprs_base #(.DATA_W(DATA_W), .NREG(NREG), .PART_W(PART_W),
               .SIGN_EXT(SIGN_EXT)) base_i (
      .part_i(f_part),
      .ri_i  (f_ri),
      .regs_i(regs_i),
      .base_o(base)
   );

   oprs_seq #(.DATA_W(DATA_W)) seq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .mode_i     (f_mode),
      .dest_i     (is_dest_op(f_opc)),
      .base_i     (base),
      .mem_valid_i(mem_valid_i),
      .mem_rdata_i(mem_rdata_i),
      .accept_o   (accept),
      .mem_req_o  (mem_req_o),
      .mem_addr_o (mem_addr_o),
      .ea_o       (ea_o),
      .operand_o  (operand_o),
      .done_o     (done_o),
      .busy_o     (busy_o),
      .illegal_o  (illegal_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         opcode_o <= '0;
         rj_o     <= '0;
      end else if (accept) begin
         opcode_o <= f_opc;
         rj_o     <= f_rj;
      end
   end

   AST_OPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> ($stable(opcode_o) && $stable(rj_o))); // R10
endmodule

// File: tb/operand_resolver_tb.sv
module operand_resolver_tb_top;
   localparam int DW = 32;

   typedef struct packed {
      logic [31:0] ins;
      logic [31:0] ea;
      logic [31:0] op;
      logic [1:0]  nrd;
      logic        ill;
   } vec_t;

   // memory word at address a: {C0DE00, a[7:0]^5A}
   localparam vec_t VEC [14] = '{
      '{{8'h02,3'd1,2'd0,3'd0,16'h0005}, 32'h0000_0005, 32'h0000_0005, 2'd0, 1'b0}, // R4
      '{{8'h11,3'd2,2'd0,3'd3,16'h0004}, 32'h0000_0034, 32'h0000_0034, 2'd0, 1'b0}, // R2
      '{{8'h12,3'd7,2'd0,3'd0,16'h0010}, 32'h0000_0010, 32'h0000_0010, 2'd0, 1'b0}, // R2 R0 unused
      '{{8'h02,3'd3,2'd0,3'd0,16'hFFFE}, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 2'd0, 1'b0}, // R3
      '{{8'h02,3'd4,2'd0,3'd5,16'h0020}, 32'h0000_0010, 32'h0000_0010, 2'd0, 1'b0}, // R3 wrap
      '{{8'h02,3'd1,2'd1,3'd0,16'h0012}, 32'h0000_0012, 32'hC0DE_0048, 2'd1, 1'b0}, // R5
      '{{8'h13,3'd5,2'd1,3'd1,16'h0003}, 32'h0000_0013, 32'hC0DE_0049, 2'd1, 1'b0}, // R5
      '{{8'h02,3'd6,2'd2,3'd0,16'h0021}, 32'hC0DE_007B, 32'hC0DE_0021, 2'd2, 1'b0}, // R6
      '{{8'h16,3'd0,2'd2,3'd4,16'h0002}, 32'hC0DE_0018, 32'hC0DE_0042, 2'd2, 1'b0}, // R6
      '{{8'h01,3'd2,2'd1,3'd0,16'h0033}, 32'h0000_0033, 32'h0000_0033, 2'd0, 1'b0}, // R7
      '{{8'h20,3'd0,2'd2,3'd0,16'h0040}, 32'hC0DE_001A, 32'hC0DE_001A, 2'd1, 1'b0}, // R7
      '{{8'h2C,3'd0,2'd0,3'd1,16'h0002}, 32'h0000_0012, 32'h0000_0012, 2'd0, 1'b0}, // R7
      '{{8'h02,3'd1,2'd3,3'd0,16'h0005}, 32'h0000_0000, 32'h0000_0000, 2'd0, 1'b1}, // R8
      '{{8'h2D,3'd3,2'd1,3'd0,16'h0005}, 32'h0000_0005, 32'hC0DE_005F, 2'd1, 1'b0}  // R7 edge
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   instr = '0;
   logic [8*DW-1:0] regs;
   logic          busy, done, ill, mreq, mvalid;
   logic [7:0]    opc;
   logic [2:0]    rj;
   logic [31:0]   ea, opnd, maddr, mrdata;

   int n_tests = 0;
   int n_fail  = 0;
   int lat     = 0;
   int rd_cnt  = 0;

   always #4 clk = ~clk; // 125 MHz

   assign regs = {32'h0000_0070, 32'h0000_0060, 32'hFFFF_FFF0, 32'h0000_0040,
                  32'h0000_0030, 32'h0000_0020, 32'h0000_0010, 32'h0000_7777};

   operand_resolver dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
      .regs_i(regs), .busy_o(busy), .done_o(done), .illegal_o(ill),
      .opcode_o(opc), .rj_o(rj), .ea_o(ea), .operand_o(opnd),
      .mem_req_o(mreq), .mem_addr_o(maddr), .mem_valid_i(mvalid),
      .mem_rdata_i(mrdata)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {24'hC0DE00, a[7:0] ^ 8'h5A};
   endfunction

   // memory model with variable latency
   logic        pend = 1'b0;
   int          cnt  = 0;
   logic [31:0] a_l  = '0;
   initial begin mvalid = 1'b0; mrdata = '0; end
   always @(posedge clk) begin
      if (mreq) rd_cnt <= rd_cnt + 1;
      mvalid <= 1'b0;
      if (mreq) begin
         pend <= 1'b1; cnt <= lat; a_l <= maddr;
      end else if (pend) begin
         if (cnt == 0) begin
            mvalid <= 1'b1; mrdata <= memf(a_l); pend <= 1'b0;
         end else cnt <= cnt - 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] ins, output int cyc, output int rds);
      int base;
      @(negedge clk);
      instr = ins; start = 1'b1; base = rd_cnt;
      @(negedge clk);
      start = 1'b0; cyc = 1;
      while (!done && cyc < 60) begin @(negedge clk); cyc++; end
      rds = rd_cnt - base;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int cyc, rds;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy", {31'd0, busy}, 32'd0);
      chk("R11 done", {31'd0, done}, 32'd0);
      chk("R11 req", {31'd0, mreq}, 32'd0);
      chk("R11 ea", ea, 32'd0);
      chk("R11 operand", opnd, 32'd0);
      chk("R11 opcode_rj", {21'd0, opc, rj}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < 14; i++) begin
         lat = i % 4;
         run(VEC[i].ins, cyc, rds);
         chk("R9 done seen", {31'd0, done}, 32'd1);
         chk("R1 opcode", {24'd0, opc}, {24'd0, VEC[i].ins[31:24]});
         chk("R1 rj", {29'd0, rj}, {29'd0, VEC[i].ins[23:21]});
         chk("R8 illegal", {31'd0, ill}, {31'd0, VEC[i].ill});
         chk("R12 read count", rds, {30'd0, VEC[i].nrd});
         if (!VEC[i].ill) begin
            chk("R2-R7 ea", ea, VEC[i].ea);
            chk("R4-R7 operand", opnd, VEC[i].op);
         end
         if (VEC[i].nrd == 2'd0) chk("R4 one-cycle done", cyc, 32'd1);
         @(negedge clk);
         chk("R9 done one cycle", {31'd0, done}, 32'd0);
         chk("R9 idle after done", {31'd0, busy}, 32'd0);
      end

      // R10: start held high, instr swapped while busy
      lat = 3;
      @(negedge clk);
      instr = {8'h02, 3'd1, 2'd1, 3'd0, 16'h0012}; start = 1'b1;
      @(negedge clk);
      instr = {8'h11, 3'd4, 2'd0, 3'd0, 16'h0077};
      cyc = 1;
      while (!done && cyc < 60) begin @(negedge clk); cyc++; end
      chk("R10 first operand", opnd, 32'hC0DE_0048);
      chk("R10 first opcode", {24'd0, opc}, 32'h02);
      @(negedge clk);
      chk("R10 start ignored in done cycle", {31'd0, busy}, 32'd0);
      @(negedge clk);
      start = 1'b0;
      chk("R10 second done", {31'd0, done}, 32'd1);
      chk("R10 second operand", opnd, 32'h77);
      chk("R10 second rj", {29'd0, rj}, 32'd4);
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule